// File: doc/BRIEF.md
# Burst-Capable 32-bit Bus Master Sequencer

This block connects an internal requester, such as a cache line-fill engine or an instruction prefetcher, to an external 32-bit memory bus. The requester presents one request at a time: a word address, byte-lane enables, write data, a direction bit and a burst flag. The block raises its grant only when it is idle. When a request is accepted, the block runs the bus cycle. It drives a one-clock address strobe and then waits for the memory to signal ready for each data beat.

A single read or single write uses one address clock and at least one data clock. A burst read fetches a whole four-word cache line with one address phase. After the first word, each further word costs one more clock. The beat addresses wrap inside the aligned line, starting at the requested word. The memory can insert any number of wait states by holding ready high.

Each read word is handed back to the requester with a valid strobe and a beat index. A one-clock done pulse marks the end of every transfer. On writes the block also drives one even-parity bit per byte lane.

Top module: `burst_bus_master`

## Requirements
- R1: While reset is held and on the first clock after it: req_ready=1, bus_ads_n=1, bus_last_n=1, bus_be_n=4'b1111, rsp_valid=0, rsp_done=0, bus_drive=0.
- R2: An accepted single read shows bus_ads_n=0 for one clock, with bus_addr=req_addr and bus_be_n equal to the inverse of req_be. With no wait states, the clock after the first data clock shows rsp_valid=1, rsp_data equal to the sampled bus_rdata, rsp_beat=0 and rsp_done=1. This is two bus clocks in total.
- R3: bus_ads_n is low for exactly one clock per transfer. It is high during every data clock.
- R4: bus_last_n is low only during data clocks. For a single transfer it is low on that transfer's data clock. For a burst it is low only during the fourth beat.
- R5: A beat completes only on a rising edge where bus_rdy_n is sampled low. While bus_rdy_n is high, no rsp_valid is produced and bus_addr stays unchanged.
- R6: A burst read (req_burst=1, req_write=0) produces four beats. Beat k uses word address {req_addr[29:2], req_addr[1:0]+k mod 4}, with bus_be_n=4'b0000. It returns rsp_beat=k. With no wait states it takes five clocks from address strobe to done.
- R7: rsp_done pulses for one clock after the final beat, in the same clock as the last read rsp_valid. req_ready is 1 in that clock.
- R8: A single write drives bus_wr=1, bus_drive=1, bus_wdata=req_wdata and bus_be_n set to the inverse of req_be. bus_wpar[i] is the XOR of data bits [8i+7:8i], which gives even parity per byte. A write produces no rsp_valid, but it does end with rsp_done.
- R9: req_burst is ignored when req_write=1. The transfer is a single write, and bus_last_n is low on its first data clock.
- R10: req_ready is 0 from acceptance until the clock of rsp_done. A request held valid during a transfer is not accepted until then. Its fields do not disturb bus_addr during the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester has a transfer to run |
| req_ready | output | 1 | Grant; high when idle |
| req_addr | input | 30 | Word address (byte address bits 31:2) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-word line fill (reads only) |
| req_be | input | 4 | Active-high byte-lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read beat data valid |
| rsp_data | output | 32 | Read beat data |
| rsp_beat | output | 2 | Beat index within the transfer |
| rsp_done | output | 1 | One-clock end-of-transfer pulse |
| bus_addr | output | 30 | External word address |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_last_n | output | 1 | Active-low final-beat marker |
| bus_wr | output | 1 | Cycle direction, 1 = write |
| bus_drive | output | 1 | Output enable for write data |
| bus_wdata | output | 32 | Write data to the bus |
| bus_wpar | output | 4 | Even parity per write byte lane |
| bus_rdata | input | 32 | Read data from the bus |
| bus_rdy_n | input | 1 | Active-low per-beat ready |

## Verification
The checker watches every clock for the bus rules that hold in any transfer:
- the strobe is a single-clock pulse, only ever following an idle clock;
- the address holds while a beat waits for ready;
- the last marker appears only inside a data phase;
- done coincides with the grant returning;
- read data never comes back during a write.

The bench scenarios establish the values the checker cannot judge on its own:
- the wrap order of burst addresses and the beat indices;
- returned data and byte enables against the request;
- per-lane write parity;
- the two-clock and five-clock minimum lengths;
- the treatment of a burst flag on writes.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    // Sequencer phases of one bus transfer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bbm_state_e;

    localparam int unsigned BBM_ADDR_W = 30;
    localparam int unsigned BBM_DATA_W = 32;
    localparam int unsigned BBM_BEATS  = 4;

endpackage

// File: rtl/bbm_lane_parity.sv
module bbm_lane_parity #(
    parameter int unsigned DW = 32,
    localparam int unsigned LANES = DW / 8
) (
    input  logic [DW-1:0]    data,
    output logic [LANES-1:0] par
);

    // One even-parity bit per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = ^data[8*g +: 8];
    end

endmodule

// File: rtl/bbm_wrap_addr.sv
module bbm_wrap_addr #(
    parameter int unsigned AW    = 30,
    parameter int unsigned BEATS = 4,
    localparam int unsigned BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [BW-1:0] beat,
    input  logic          burst,
    output logic [AW-1:0] next_addr,
    output logic          is_last
);

    logic [BW-1:0] low_inc;

    // Step the in-line word offset and wrap inside the aligned line
    assign low_inc   = cur_addr[BW-1:0] + BW'(1);
    assign next_addr = {cur_addr[AW-1:BW], low_inc};
    assign is_last   = !burst || (beat == BW'(BEATS - 1));

endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
    import bbm_pkg::*;
#(
    parameter int unsigned AW    = BBM_ADDR_W,
    parameter int unsigned DW    = BBM_DATA_W,
    parameter int unsigned BEATS = BBM_BEATS,
    localparam int unsigned LANES = DW / 8,
    localparam int unsigned BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic             req_burst,
    input  logic [LANES-1:0] req_be,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic [BW-1:0]    rsp_beat,
    output logic             rsp_done,
    output logic [AW-1:0]    bus_addr,
    output logic [LANES-1:0] bus_be_n,
    output logic             bus_ads_n,
    output logic             bus_last_n,
    output logic             bus_wr,
    output logic             bus_drive,
    output logic [DW-1:0]    bus_wdata,
    output logic [LANES-1:0] bus_wpar,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_rdy_n
);

    typedef struct packed {
        bbm_state_e       st;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be_n;
        logic [DW-1:0]    wdata;
        logic             wr;
        logic             burst;
        logic [BW-1:0]    beat;
        logic             rsp_valid;
        logic [DW-1:0]    rsp_data;
        logic [BW-1:0]    rsp_beat;
        logic             rsp_done;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] wrap_addr;
    logic          beat_last;

    bbm_wrap_addr #(
        .AW    (AW),
        .BEATS (BEATS)
    ) u_wrap (
        .cur_addr  (r_q.addr),
        .beat      (r_q.beat),
        .burst     (r_q.burst),
        .next_addr (wrap_addr),
        .is_last   (beat_last)
    );

    bbm_lane_parity #(
        .DW (DW)
    ) u_par (
        .data (r_q.wdata),
        .par  (bus_wpar)
    );

    // Next-state computation
    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.rsp_done  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_ADDR;
                    r_d.addr  = req_addr;
                    r_d.wr    = req_write;
                    r_d.burst = req_burst && !req_write;
                    r_d.be_n  = (req_burst && !req_write) ? '0 : ~req_be;
                    r_d.wdata = req_wdata;
                    r_d.beat  = '0;
                end
            end
            ST_ADDR: begin
                r_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (!bus_rdy_n) begin
                    if (!r_q.wr) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_data  = bus_rdata;
                        r_d.rsp_beat  = r_q.beat;
                    end
                    if (beat_last) begin
                        r_d.st       = ST_IDLE;
                        r_d.rsp_done = 1'b1;
                    end else begin
                        r_d.beat = r_q.beat + BW'(1);
                        r_d.addr = wrap_addr;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.be_n      <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_data   = r_q.rsp_data;
    assign rsp_beat   = r_q.rsp_beat;
    assign rsp_done   = r_q.rsp_done;
    assign bus_addr   = r_q.addr;
    assign bus_be_n   = r_q.be_n;
    assign bus_ads_n  = (r_q.st != ST_ADDR);
    assign bus_last_n = !((r_q.st == ST_DATA) && beat_last);
    assign bus_wr     = r_q.wr;
    assign bus_drive  = r_q.wr && (r_q.st != ST_IDLE);
    assign bus_wdata  = r_q.wdata;

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int unsigned AW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          bus_ads_n,
    input logic          bus_last_n,
    input logic          bus_rdy_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          rsp_valid,
    input logic          rsp_done
);

    assert_ads_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads_n |=> bus_ads_n);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && (bus_rdy_n || !bus_ads_n)) |=> $stable(bus_addr));

    assert_last_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_last_n |-> (!req_ready && bus_ads_n));

    assert_done_grants_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    assert_strobe_after_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ads_n) |-> $past(req_ready));

    assert_no_read_data_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_wr);

endmodule

bind burst_bus_master bbm_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .bus_ads_n  (bus_ads_n),
    .bus_last_n (bus_last_n),
    .bus_rdy_n  (bus_rdy_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .rsp_valid  (rsp_valid),
    .rsp_done   (rsp_done)
);

// File: tb/burst_bus_master_test.sv
module burst_bus_master_test;

    typedef struct packed {
        logic        wr;
        logic        burst;
        logic [29:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [3:0]  waits;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 30'h0000_1234, 4'b1111, 32'h0,          4'd0},
        '{1'b0, 1'b0, 30'h0000_2001, 4'b0101, 32'h0,          4'd2},
        '{1'b0, 1'b1, 30'h0000_3006, 4'b0001, 32'h0,          4'd0},
        '{1'b0, 1'b1, 30'h0123_4567, 4'b1000, 32'h0,          4'd1},
        '{1'b1, 1'b0, 30'h0000_0040, 4'b1111, 32'h1234_5678,  4'd0},
        '{1'b1, 1'b0, 30'h3FFF_FFF1, 4'b0011, 32'h80FF_0107,  4'd3},
        '{1'b1, 1'b1, 30'h0000_0502, 4'b1100, 32'hA5C3_0F01,  4'd0},
        '{1'b0, 1'b1, 30'h0000_7770, 4'b1111, 32'h0,          4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [29:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_burst = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_beat;
    logic        rsp_done;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be_n;
    logic        bus_ads_n;
    logic        bus_last_n;
    logic        bus_wr;
    logic        bus_drive;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_wpar;
    logic [31:0] bus_rdata = '0;
    logic        bus_rdy_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    burst_bus_master uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_burst(req_burst), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_beat(rsp_beat), .rsp_done(rsp_done), .bus_addr(bus_addr),
        .bus_be_n(bus_be_n), .bus_ads_n(bus_ads_n), .bus_last_n(bus_last_n),
        .bus_wr(bus_wr), .bus_drive(bus_drive), .bus_wdata(bus_wdata),
        .bus_wpar(bus_wpar), .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_model(input logic [29:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [3:0] even_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    task automatic run_txn(input vec_t v);
        int nb;
        logic [29:0] ea;
        logic [29:0] prev_ea;
        logic [3:0]  exp_be_n;
        nb = (v.burst && !v.wr) ? 4 : 1;
        exp_be_n = (nb == 4) ? 4'b0000 : ~v.be;
        prev_ea = v.addr;
        @(negedge clk);
        chk("R7", "idle grant", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = v.addr; req_write = v.wr;
        req_burst = v.burst; req_be = v.be; req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "strobe low", 32'(bus_ads_n), 32'd0);
        chk("R2", "address phase addr", 32'(bus_addr), 32'(v.addr));
        chk(nb == 4 ? "R6" : "R2", "byte enables", 32'(bus_be_n), 32'(exp_be_n));
        chk("R10", "busy", 32'(req_ready), 32'd0);
        chk("R4", "no last in address phase", 32'(bus_last_n), 32'd1);
        for (int b = 0; b < nb; b++) begin
            ea = {v.addr[29:2], 2'(v.addr[1:0] + 2'(b))};
            for (int w = 0; w <= int'(v.waits); w++) begin
                if (w > 0 || b > 0) @(negedge clk);
                else @(negedge clk);
                chk("R3", "strobe high in data", 32'(bus_ads_n), 32'd1);
                chk(nb == 4 ? "R6" : "R5", "beat addr", 32'(bus_addr), 32'(ea));
                chk(v.wr && v.burst ? "R9" : "R4", "last marker",
                    32'(bus_last_n), (b == nb - 1) ? 32'd0 : 32'd1);
                if (w == 0 && b > 0) begin
                    chk("R6", "beat valid", 32'(rsp_valid), 32'd1);
                    chk("R6", "beat data", rsp_data, mem_model(prev_ea));
                    chk("R6", "beat index", 32'(rsp_beat), 32'(b - 1));
                    chk("R7", "no early done", 32'(rsp_done), 32'd0);
                end else begin
                    chk("R5", "no beat without ready", 32'(rsp_valid), 32'd0);
                end
                if (v.wr) begin
                    chk("R8", "write dir", 32'(bus_wr), 32'd1);
                    chk("R8", "drive", 32'(bus_drive), 32'd1);
                    chk("R8", "write data", bus_wdata, v.wdata);
                    chk("R8", "parity", 32'(bus_wpar), 32'(even_par(v.wdata)));
                end
                bus_rdy_n = (w == int'(v.waits)) ? 1'b0 : 1'b1;
                bus_rdata = (w == int'(v.waits)) ? mem_model(ea) : 32'hDEAD_BEEF;
            end
            prev_ea = ea;
        end
        @(negedge clk);
        bus_rdy_n = 1'b1;
        chk("R7", "done pulse", 32'(rsp_done), 32'd1);
        chk("R7", "grant back", 32'(req_ready), 32'd1);
        if (v.wr) begin
            chk("R8", "no read data on write", 32'(rsp_valid), 32'd0);
        end else begin
            chk(nb == 4 ? "R6" : "R2", "last valid", 32'(rsp_valid), 32'd1);
            chk(nb == 4 ? "R6" : "R2", "last data", rsp_data, mem_model(prev_ea));
            chk(nb == 4 ? "R6" : "R2", "last index", 32'(rsp_beat), 32'(nb - 1));
        end
        @(negedge clk);
        chk("R7", "done one clock", 32'(rsp_done), 32'd0);
    endtask

    task automatic check_reset_state(input string tag);
        chk("R1", {tag, " ready"}, 32'(req_ready), 32'd1);
        chk("R1", {tag, " ads"}, 32'(bus_ads_n), 32'd1);
        chk("R1", {tag, " last"}, 32'(bus_last_n), 32'd1);
        chk("R1", {tag, " be"}, 32'(bus_be_n), 32'hF);
        chk("R1", {tag, " valid"}, 32'(rsp_valid), 32'd0);
        chk("R1", {tag, " done"}, 32'(rsp_done), 32'd0);
        chk("R1", {tag, " drive"}, 32'(bus_drive), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after reset");

        // Table-driven transfers
        for (int i = 0; i < NV; i++) run_txn(VECS[i]);

        // R10: request held during a busy transfer is not taken early
        @(negedge clk);
        req_valid = 1'b1; req_addr = 30'h0000_0AA1; req_write = 1'b0;
        req_burst = 1'b0; req_be = 4'b1111;
        @(negedge clk);
        req_addr = 30'h0000_0BB2;
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            chk("R10", "no second strobe", 32'(bus_ads_n), 32'd1);
            chk("R10", "addr held", 32'(bus_addr), 32'h0000_0AA1);
            chk("R10", "still busy", 32'(req_ready), 32'd0);
        end
        bus_rdy_n = 1'b0; bus_rdata = 32'h1357_9BDF;
        @(negedge clk);
        bus_rdy_n = 1'b1;
        chk("R7", "held-case done", 32'(rsp_done), 32'd1);
        chk("R5", "held-case data", rsp_data, 32'h1357_9BDF);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10", "second accepted after done", 32'(bus_ads_n), 32'd0);
        chk("R10", "second addr", 32'(bus_addr), 32'h0000_0BB2);
        @(negedge clk);
        bus_rdy_n = 1'b0;
        @(negedge clk);
        bus_rdy_n = 1'b1;
        chk("R7", "second done", 32'(rsp_done), 32'd1);

        // R1: reset in the middle of a burst
        @(negedge clk);
        req_valid = 1'b1; req_addr = 30'h0000_0C03; req_burst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        bus_rdy_n = 1'b0;
        @(negedge clk);
        bus_rdy_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-burst reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after mid-burst reset");

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule